// File: doc/BRIEF.md
# Fixed-Latency Read Playback Line

This block is a circular delay line for a banked memory controller that promises a fixed, deterministic read latency. Every clock cycle it records one small entry: whether a read request was accepted that cycle and, if so, the row of the data-holding buffer that the request was given. Exactly `DELAY` cycles later the same entry comes back out. The returned flag and row id tell the surrounding controller when to drive the buffered read data to the interface and which buffer row to read and release.

The line is written every cycle, idle or not, so the replayed stream holds one entry per input cycle in the original order. Storage is split into two sets of `DELAY/2` entries. Each set has a single read-write port. Consecutive cycles alternate between the sets, so in any cycle one set takes the write while the other serves the read. The in-set index advances once every two cycles. The read position runs one slot ahead of the write position. The read result passes through one more register before it reaches the outputs.

Top module: `pb_playback_line`

## Requirements
- R1: An entry sampled at a rising edge with `in_vld` high appears on `out_vld`/`out_row` immediately after the `DELAY`-th following rising edge, holding the same row id, for one cycle.
- R2: An input cycle with `in_vld` low replays as `out_vld` low, and `out_row` reads all zeros whenever `out_vld` is low, whatever value `in_row` had.
- R3: While `rst_n` is low, and for the first `DELAY` rising edges after it is released, `out_vld` is low and `out_row` is zero, whatever the inputs are.
- R4: Back-to-back valid inputs, one per cycle, replay one per cycle in the same order, each with its own row id, with no entry lost or duplicated.
- R5: Storage is two single-port sets of `DELAY/2` entries each. In every cycle one set is written and the other is read, and the written set alternates from cycle to cycle.
- R6: Within a set, the entry index stays the same across the two cycles of a pair and advances after each pair, wrapping at `DELAY/2`.
- R7: Asserting `rst_n` while entries are in flight discards them: after release, the outputs stay quiet as in R3, and only inputs given after the release are replayed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | A read was accepted this cycle |
| in_row | input | ROW_W | Buffer row assigned to the accepted read |
| out_vld | output | 1 | Replayed read flag, `DELAY` cycles after the input |
| out_row | output | ROW_W | Replayed row id; zero when `out_vld` is low |

## Verification
An input sampled at a rising edge must show up right after the `DELAY`-th following edge. The bench drives every input on a falling edge and keeps a history of what it drove, indexed by falling edge. At falling edge n it compares the outputs with the input driven at falling edge n−1−`DELAY`. Until that index exists after a reset, it expects a quiet output instead. In this way, single pulses, full-rate bursts, idle cycles with stray row values, irregular patterns and a reset in mid-stream are all checked on the exact cycle they are due, never a cycle early or late.

// File: rtl/pb_pkg.sv
`timescale 1ns/1ps
package pb_pkg;

  // next slot of a circular line of the given length
  function automatic int slot_next(input int slot, input int len);
    return (slot + 1 == len) ? 0 : slot + 1;
  endfunction

  // which of the two storage sets a slot lives in
  function automatic int slot_set(input int slot);
    return slot % 2;
  endfunction

  // index inside its set; two neighbouring slots share one index
  function automatic int slot_index(input int slot);
    return slot / 2;
  endfunction

endpackage

// File: rtl/pb_bank.sv
`timescale 1ns/1ps
module pb_bank #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // single port: a cycle is either a write or a synchronous read
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    else    rdata     <= mem[addr];
  end

endmodule

// File: rtl/pb_sequencer.sv
`timescale 1ns/1ps
module pb_sequencer
  import pb_pkg::*;
#(
  parameter int DELAY = 32,
  localparam int SLOT_W = $clog2(DELAY),
  localparam int IDX_W  = $clog2(DELAY / 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             wr_set,
  output logic [IDX_W-1:0] wr_idx,
  output logic             rd_set,
  output logic [IDX_W-1:0] rd_idx,
  output logic             rd_ok
);

  logic [SLOT_W-1:0] slot_q;
  logic              warm_q;
  logic              started_q;
  int                rd_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q    <= '0;
      warm_q    <= 1'b0;
      started_q <= 1'b0;
    end else begin
      slot_q    <= SLOT_W'(slot_next(int'(slot_q), DELAY));
      started_q <= 1'b1;
      if (int'(slot_q) == DELAY - 1) warm_q <= 1'b1;
    end
  end

  // read position runs one slot ahead of the write position
  always_comb begin
    rd_slot = slot_next(int'(slot_q), DELAY);
    wr_set  = slot_set(int'(slot_q)) == 1;
    wr_idx  = IDX_W'(slot_index(int'(slot_q)));
    rd_set  = slot_set(rd_slot) == 1;
    rd_idx  = IDX_W'(slot_index(rd_slot));
    // slot 0 is read when the write slot is last; all later reads are filled
    rd_ok   = warm_q | (int'(slot_q) == DELAY - 1);
  end

  // R5: write and read never share a set
  assert_sets_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set != rd_set);

  // R5: the written set alternates every cycle
  assert_set_toggles_R5: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> (wr_set != $past(wr_set)));

  // R6: index holds across the two cycles of a pair
  assert_index_pairs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && !$past(wr_set)) |-> (wr_idx == $past(wr_idx)));

  // R6: index moves on after the pair
  assert_index_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && $past(wr_set)) |-> (wr_idx != $past(wr_idx)));

endmodule

// File: rtl/pb_replay_stage.sv
`timescale 1ns/1ps
module pb_replay_stage #(
  parameter int ROW_W = 3,
  localparam int ENT_W = ROW_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_set,
  input  logic             rd_ok,
  input  logic [ENT_W-1:0] set0_rdata,
  input  logic [ENT_W-1:0] set1_rdata,
  output logic             out_vld,
  output logic [ROW_W-1:0] out_row
);

  logic             sel_q;
  logic             ok_q;
  logic [ENT_W-1:0] pick;
  logic             hit;
  logic [ROW_W-1:0] row_nx;

  // remember which set was read and whether that slot held real data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      ok_q  <= 1'b0;
    end else begin
      sel_q <= rd_set;
      ok_q  <= rd_ok;
    end
  end

  always_comb begin
    pick   = sel_q ? set1_rdata : set0_rdata;
    hit    = pick[ROW_W] & ok_q;
    row_nx = hit ? pick[ROW_W-1:0] : '0;
  end

  // extra output register completes the fixed delay
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_row <= '0;
    end else begin
      out_vld <= hit;
      out_row <= row_nx;
    end
  end

  // R2: an invalid replay carries a zero row
  assert_idle_row_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (out_row == '0));

endmodule

// File: rtl/pb_playback_line.sv
`timescale 1ns/1ps
module pb_playback_line #(
  parameter int DELAY = 32,
  parameter int ROW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [ROW_W-1:0] in_row,
  output logic             out_vld,
  output logic [ROW_W-1:0] out_row
);

  localparam int SET_D = DELAY / 2;
  localparam int IDX_W = $clog2(SET_D);
  localparam int ENT_W = ROW_W + 1;
  localparam int CW    = $clog2(DELAY + 2);

  logic             wr_set;
  logic             rd_set;
  logic             rd_ok;
  logic [IDX_W-1:0] wr_idx;
  logic [IDX_W-1:0] rd_idx;
  logic [ENT_W-1:0] wentry;
  logic [ENT_W-1:0] set_rdata [2];

  pb_sequencer #(.DELAY(DELAY)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_set (wr_set),
    .wr_idx (wr_idx),
    .rd_set (rd_set),
    .rd_idx (rd_idx),
    .rd_ok  (rd_ok)
  );

  // idle cycles store a cleared flag and a zero row
  assign wentry = {in_vld, in_vld ? in_row : {ROW_W{1'b0}}};

  for (genvar s = 0; s < 2; s++) begin : g_set
    logic             we_s;
    logic [IDX_W-1:0] addr_s;
    assign we_s   = (wr_set == (s == 1));
    assign addr_s = we_s ? wr_idx : rd_idx;
    pb_bank #(.WIDTH(ENT_W), .DEPTH(SET_D)) u_bank (
      .clk   (clk),
      .we    (we_s),
      .addr  (addr_s),
      .wdata (wentry),
      .rdata (set_rdata[s])
    );
  end

  pb_replay_stage #(.ROW_W(ROW_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_set     (rd_set),
    .rd_ok      (rd_ok),
    .set0_rdata (set_rdata[0]),
    .set1_rdata (set_rdata[1]),
    .out_vld    (out_vld),
    .out_row    (out_row)
  );

  // edges since reset, saturating; used only by the checks below
  logic [CW-1:0] since_rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              since_rst_q <= '0;
    else if (int'(since_rst_q) <= DELAY)     since_rst_q <= since_rst_q + 1'b1;
  end

  // R3 and R7: nothing replays during the first DELAY edges after reset
  assert_quiet_after_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(since_rst_q) <= DELAY) |-> !out_vld);

  // R1: the replayed flag is always a known value
  assert_flag_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(out_vld));

endmodule

// File: tb/test_pb_playback_line.sv
`timescale 1ns/1ps
module test_pb_playback_line;

  localparam int DLY = 32;
  localparam int RW  = 3;
  localparam int HL  = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_vld = 1'b0;
  logic [RW-1:0] in_row = '0;
  logic          out_vld;
  logic [RW-1:0] out_row;

  int checks = 0;
  int errors = 0;
  int n = 0;
  logic          hv [HL];
  logic [RW-1:0] hr [HL];

  always #10 clk = ~clk;

  pb_playback_line #(.DELAY(DLY), .ROW_W(RW)) i_pb_playback_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_row  (in_row),
    .out_vld (out_vld),
    .out_row (out_row)
  );

  task automatic check(input string tag, input logic ev, input logic [RW-1:0] er);
    checks++;
    if (out_vld !== ev || out_row !== er) begin
      errors++;
      $display("FAIL %s: step %0d got vld=%0b row=%0d, expected vld=%0b row=%0d",
               tag, n, out_vld, out_row, ev, er);
    end
  endtask

  // one cycle: check what is due now, then drive the next input
  task automatic step(input string tag, input logic v, input logic [RW-1:0] r);
    int m;
    @(negedge clk);
    m = n - 1 - DLY;
    if (m < 0) check((tag == "R7") ? "R7" : "R3", 1'b0, '0);
    else       check(tag, hv[m % HL], hr[m % HL]);
    in_vld = v;
    in_row = r;
    hv[n % HL] = v;
    hr[n % HL] = v ? r : '0;
    n++;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < DLY + 2; i++) step(tag, 1'b0, 3'd7);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n  = 1'b0;
    in_vld = 1'b1;
    in_row = 3'd5;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(tag, 1'b0, '0);
    end
    rst_n  = 1'b1;
    in_vld = 1'b0;
    in_row = '0;
    hv[0]  = 1'b0;
    hr[0]  = '0;
    n      = 1;
  endtask

  // R3: quiet during and after reset even with valid input every cycle
  task automatic t_reset_quiet_r3;
    do_reset("R3");
    for (int i = 0; i < DLY + 4; i++) step("R3", 1'b1, RW'(i));
    drain("R4");
  endtask

  // R1: a lone request returns after exactly DELAY edges
  task automatic t_single_r1;
    step("R1", 1'b1, 3'd5);
    drain("R1");
    step("R1", 1'b1, 3'd2);
    step("R1", 1'b0, 3'd0);
    step("R1", 1'b1, 3'd6);
    drain("R1");
  endtask

  // R4: full-rate burst, each row replayed in order
  task automatic t_burst_r4;
    for (int i = 0; i < 2 * DLY + 5; i++) step("R4", 1'b1, RW'(i * 3 + 1));
    drain("R4");
  endtask

  // R2: idle cycles with stray row values replay as invalid, zero row
  task automatic t_idle_r2;
    for (int i = 0; i < DLY + 6; i++)
      step("R2", (i % 4) == 0, RW'(7 - (i % 8)));
    drain("R2");
  endtask

  // R5 and R6: irregular pattern over several wraps touching every slot of both sets
  task automatic t_sets_r5_r6;
    logic [7:0] lfsr = 8'hA5;
    for (int i = 0; i < 3 * DLY + 7; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step((i % 2) ? "R5" : "R6", lfsr[0] | lfsr[3], lfsr[6:4]);
    end
    drain("R5");
  endtask

  // R7: reset with requests in flight drops them
  task automatic t_midreset_r7;
    for (int i = 0; i < DLY / 2 + 3; i++) step("R7", 1'b1, RW'(i));
    do_reset("R7");
    for (int i = 0; i < DLY + 1; i++) step("R7", 1'b0, 3'd3);
    step("R7", 1'b1, 3'd4);
    drain("R7");
  endtask

  initial begin
    t_reset_quiet_r3();
    t_single_r1();
    t_burst_r4();
    t_idle_r2();
    t_sets_r5_r6();
    t_midreset_r7();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule